// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset causes into one internal reset for a small microcontroller core. The causes are an external reset pin, a hardware watchdog overflow and a timer-module watchdog compare match. The pin counts as a reset only after it has stayed high for a minimum run of clocks. A watchdog request, which may last a single cycle, is stretched by a small counter that advances once every second clock. The stretched request therefore covers the same minimum length as a valid pin reset.

The merged request is examined on a two-clock cadence. When it is seen, a restart sequencer takes over. It asserts the core reset and gives one load pulse for the special-function registers. When the request goes away it runs one synchronizing cycle and then a configuration-fetch handshake. It finishes by presenting a fixed 24-bit start address with a valid strobe.

Whenever any request is present, a port-force output drives the pins to their safe state straight away, through logic only. A power-off flag tells a cold start from a warm one. The flag is set when the supply-good input rises, warm resets leave it alone, and software can write it.

Top module: `rst_sequencer`

## Requirements
- R1: The external pin qualifies as a reset only after 64 or more consecutive clocks high. A run of 63 or fewer clocks never asserts core_rst.
- R2: A one-cycle request on wdt_ovf or on wdt_cmp holds the merged request for 64 clocks, counted in 32 two-clock ticks. The resulting core_rst pulse lasts between 60 and 70 clocks.
- R3: A new watchdog request during a stretch that is already running reloads the stretch counter. A second request 40 clocks after the first gives a core_rst pulse of 98 to 110 clocks.
- R4: port_force is high, through logic only and with no clock edge needed, whenever any raw request input is high. It also stays high while a qualified request or core_rst is active.
- R5: core_rst only changes on a sample tick. The tick occurs on every second clock after reset.
- R6: sfr_load is a single-cycle pulse. It is given exactly once, on entry to the reset state, in each reset sequence.
- R7: After core_rst falls, fetch_req is raised and held until fetch_ack is seen. start_valid is never asserted before fetch_ack.
- R8: start_valid pulses for exactly one cycle after the fetch completes, with start_addr equal to 24'hFF0000.
- R9: pof is set on a rising edge of supply_ok. Warm resets leave it unchanged. Otherwise it takes pof_wr_data when pof_wr_en is high, and a supply rise wins over a write in the same cycle.
- R10: While rst is high and just after it, core_rst, sfr_load, fetch_req, start_valid and pof are 0. port_force is also 0 when no request input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_rst_pin | input | 1 | External reset pin (already synchronized) |
| wdt_ovf | input | 1 | Hardware watchdog overflow request |
| wdt_cmp | input | 1 | Timer-module watchdog compare-match request |
| supply_ok | input | 1 | Digital power-on-detect, high at operating supply |
| pof_wr_en | input | 1 | Software write enable for the power-off flag |
| pof_wr_data | input | 1 | Value written to the power-off flag |
| fetch_ack | input | 1 | Configuration fetch completion |
| port_force | output | 1 | Forces port pins to their safe state |
| core_rst | output | 1 | Internal reset to the core |
| sfr_load | output | 1 | One-cycle pulse to load register reset values |
| fetch_req | output | 1 | Configuration fetch request |
| start_valid | output | 1 | Start address valid strobe |
| start_addr | output | 24 | Execution start address |
| pof | output | 1 | Power-off flag, 1 after a cold start |

## Verification
The embedded assertions check these rules on every cycle:
- core_rst moves only on a sample tick.
- sfr_load is a lone single-cycle pulse inside the reset state.
- a watchdog request reloads the stretch to its full count, and each tick lowers it by one.
- a qualified pin implies the pin was high on the previous cycle.
- start_valid is always preceded by fetch_ack.
- a supply rise sets pof.

Only the directed scenarios can show the end-to-end lengths: the 63-versus-70-clock pin boundary, the 64-clock stretch and the longer stretch after a retrigger. They also show the handshake holding for a delayed acknowledge, pof staying unchanged across warm resets, and port_force reacting between clock edges.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int unsigned PIN_MIN_CLKS = 64;
    localparam int unsigned STRETCH_W    = 5;
    localparam int unsigned ADDR_W       = 24;
    localparam logic [ADDR_W-1:0] START_VECTOR = 24'hFF0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET_ACTIVE,
        ST_SYNC,
        ST_CONFIG_FETCH,
        ST_VECTOR
    } seq_state_t;

    typedef struct packed {
        logic pin;
        logic ovf;
        logic cmp;
    } req_raw_t;

    function automatic logic any_raw(input req_raw_t r);
        return r.pin | r.ovf | r.cmp;
    endfunction

endpackage

// File: rtl/rst_tick_gen.sv
module rst_tick_gen (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= ~tick;
    end
endmodule

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
    parameter int unsigned MIN_CLKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic qualified
);
    localparam int unsigned CW = $clog2(MIN_CLKS);
    localparam logic [CW-1:0] LAST = CW'(MIN_CLKS - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pin) begin
            run_cnt   <= '0;
            qualified <= 1'b0;
        end else if (run_cnt != LAST) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            qualified <= 1'b1;
        end
    end

    // R1
    pin_qual_chk: assert property (@(posedge clk) disable iff (rst)
        qualified |-> $past(pin));
endmodule

// File: rtl/rst_wdt_stretch.sv
module rst_wdt_stretch #(
    parameter int unsigned CW = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    output logic active
);
    localparam logic [CW-1:0] FULL = '1;

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (req) begin
            active <= 1'b1;
            remain <= FULL;
        end else if (active && tick) begin
            if (remain == '0) active <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // R3
    stretch_load_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> (active && remain == FULL));

    // R2
    stretch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !req && remain != '0) |=> (active && remain == $past(remain) - 1'b1));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_pin,
    input  logic              wdt_ovf,
    input  logic              wdt_cmp,
    input  logic              supply_ok,
    input  logic              pof_wr_en,
    input  logic              pof_wr_data,
    input  logic              fetch_ack,
    output logic              port_force,
    output logic              core_rst,
    output logic              sfr_load,
    output logic              fetch_req,
    output logic              start_valid,
    output logic [ADDR_W-1:0] start_addr,
    output logic              pof
);
    req_raw_t   raw;
    logic       tick, pin_ok, wdt_active, merged;
    seq_state_t state, state_n;
    logic       supply_q;

    assign raw = '{pin: ext_rst_pin, ovf: wdt_ovf, cmp: wdt_cmp};

    rst_tick_gen u_tick (.clk(clk), .rst(rst), .tick(tick));

    rst_pin_qual #(.MIN_CLKS(PIN_MIN_CLKS)) u_pin (
        .clk(clk), .rst(rst), .pin(raw.pin), .qualified(pin_ok)
    );

    rst_wdt_stretch #(.CW(STRETCH_W)) u_wdt (
        .clk(clk), .rst(rst), .tick(tick), .req(raw.ovf | raw.cmp), .active(wdt_active)
    );

    assign merged     = pin_ok | wdt_active;
    assign port_force = any_raw(raw) | merged | core_rst;

    always_comb begin
        state_n = state;
        if (tick && merged) begin
            state_n = ST_RESET_ACTIVE;
        end else begin
            unique case (state)
                ST_IDLE:         state_n = ST_IDLE;
                ST_RESET_ACTIVE: if (tick) state_n = ST_SYNC;
                ST_SYNC:         state_n = ST_CONFIG_FETCH;
                ST_CONFIG_FETCH: if (fetch_ack) state_n = ST_VECTOR;
                ST_VECTOR:       state_n = ST_IDLE;
                default:         state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sfr_load <= 1'b0;
        end else begin
            state    <= state_n;
            sfr_load <= (state_n == ST_RESET_ACTIVE) && (state != ST_RESET_ACTIVE);
        end
    end

    assign core_rst    = (state == ST_RESET_ACTIVE);
    assign fetch_req   = (state == ST_CONFIG_FETCH);
    assign start_valid = (state == ST_VECTOR);
    assign start_addr  = START_VECTOR;

    always_ff @(posedge clk) begin
        if (rst) begin
            pof      <= 1'b0;
            supply_q <= supply_ok;
        end else begin
            supply_q <= supply_ok;
            if (supply_ok && !supply_q) pof <= 1'b1;
            else if (pof_wr_en)         pof <= pof_wr_data;
        end
    end

    // R5
    core_rst_cadence_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_rst) || $fell(core_rst)) |-> $past(tick));

    // R6
    sfr_load_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        sfr_load |-> (core_rst && !$past(core_rst)));

    // R6
    sfr_load_single_chk: assert property (@(posedge clk) disable iff (rst)
        sfr_load |=> !sfr_load);

    // R8
    vector_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> $past(fetch_ack));

    // R9
    pof_cold_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_ok) |=> pof);

    // R4
    port_force_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> port_force);
endmodule

// File: tb/tb_rst_sequencer.sv
module tb_rst_sequencer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst, ext_rst_pin, wdt_ovf, wdt_cmp, supply_ok, pof_wr_en, pof_wr_data, fetch_ack;
    logic port_force, core_rst, sfr_load, fetch_req, start_valid, pof;
    logic [23:0] start_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_sequencer dut (
        .clk(clk), .rst(rst), .ext_rst_pin(ext_rst_pin), .wdt_ovf(wdt_ovf), .wdt_cmp(wdt_cmp),
        .supply_ok(supply_ok), .pof_wr_en(pof_wr_en), .pof_wr_data(pof_wr_data),
        .fetch_ack(fetch_ack), .port_force(port_force), .core_rst(core_rst),
        .sfr_load(sfr_load), .fetch_req(fetch_req), .start_valid(start_valid),
        .start_addr(start_addr), .pof(pof)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Runs one scenario window: drives the pin and watchdog pulses, answers fetch_req, collects stats.
    task automatic observe(input int pin_clks, input int wdt_sel, input int retrig_at,
                           input int ack_delay,
                           output int rst_len, output int sfr_cnt, output int sv_cnt,
                           output logic [23:0] addr, output int early_sv);
        int req_cnt = 0;
        bit acked = 0;
        rst_len = 0; sfr_cnt = 0; sv_cnt = 0; early_sv = 0; addr = '0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (core_rst) rst_len++;
            if (sfr_load) sfr_cnt++;
            if (start_valid) begin
                sv_cnt++;
                addr = start_addr;
                if (!acked) early_sv++;
            end
            ext_rst_pin = (i < pin_clks);
            wdt_ovf = (wdt_sel == 1) && (i == 0 || i == retrig_at);
            wdt_cmp = (wdt_sel == 2) && (i == 0 || i == retrig_at);
            fetch_ack = 1'b0;
            if (fetch_req) begin
                req_cnt++;
                if (req_cnt >= ack_delay && !acked) begin
                    fetch_ack = 1'b1;
                    acked = 1;
                end
            end
        end
        fetch_ack = 1'b0;
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        check(!core_rst && !sfr_load && !fetch_req && !start_valid, "R10 outputs idle",
              int'({core_rst, sfr_load, fetch_req, start_valid}), 0);
        check(!port_force, "R10 port_force low", int'(port_force), 0);
        check(!pof, "R10 pof low", int'(pof), 0);
    endtask

    task automatic test_cold_start();
        @(negedge clk) supply_ok = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(pof, "R9 pof set on supply rise", int'(pof), 1);
    endtask

    task automatic test_short_pin();
        int l, s, v, e; logic [23:0] a;
        observe(63, 0, -1, 1, l, s, v, a, e);
        check(l == 0 && v == 0, "R1 63-clock pin ignored", l, 0);
    endtask

    task automatic test_long_pin();
        int l, s, v, e; logic [23:0] a;
        observe(100, 0, -1, 1, l, s, v, a, e);
        check(l >= 32 && l <= 42, "R1 100-clock pin reset length", l, 37);
        check(s == 1, "R6 one sfr_load", s, 1);
        check(v == 1, "R8 one start_valid", v, 1);
        check(a == 24'hFF0000, "R8 start address", int'(a), int'(24'hFF0000));
    endtask

    task automatic test_pin_70();
        int l, s, v, e; logic [23:0] a;
        observe(70, 0, -1, 1, l, s, v, a, e);
        check(l > 0 && v == 1, "R1 70-clock pin qualifies", l, 6);
    endtask

    task automatic test_wdt(input int sel, input string tag);
        int l, s, v, e; logic [23:0] a;
        observe(0, sel, -1, 10, l, s, v, a, e);
        check(l >= 60 && l <= 70, {"R2 stretch length ", tag}, l, 65);
        check(e == 0, "R7 no start_valid before ack", e, 0);
        check(v == 1 && s == 1, "R8 R6 single strobes", v * 10 + s, 11);
        check(pof, "R9 warm reset keeps pof", int'(pof), 1);
    endtask

    task automatic test_retrigger();
        int l, s, v, e; logic [23:0] a;
        observe(0, 1, 40, 3, l, s, v, a, e);
        check(l >= 98 && l <= 110, "R3 retrigger extends stretch", l, 104);
        check(s == 1, "R6 one sfr_load on retrigger", s, 1);
    endtask

    task automatic test_fetch_hold();
        int held = 0;
        @(negedge clk) wdt_cmp = 1'b1;
        @(negedge clk) wdt_cmp = 1'b0;
        for (int i = 0; i < 200 && !fetch_req; i++) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fetch_req && !start_valid) held++;
        end
        check(held == 20, "R7 fetch_req held without ack", held, 20);
        fetch_ack = 1'b1;
        @(negedge clk) fetch_ack = 1'b0;
        check(start_valid && !fetch_req, "R8 vector after ack", int'(start_valid), 1);
        @(negedge clk);
        check(!start_valid, "R8 start_valid one cycle", int'(start_valid), 0);
    endtask

    task automatic test_async_force();
        @(negedge clk);
        #1 wdt_ovf = 1'b1;
        #1 check(port_force, "R4 immediate force on wdt_ovf", int'(port_force), 1);
        wdt_ovf = 1'b0;
        #1 ext_rst_pin = 1'b1;
        #1 check(port_force, "R4 immediate force on pin", int'(port_force), 1);
        ext_rst_pin = 1'b0;
        for (int i = 0; i < 120; i++) @(negedge clk);
        fetch_ack = 1'b1;
        @(negedge clk) fetch_ack = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        check(!port_force && !core_rst, "R4 force released", int'(port_force), 0);
    endtask

    task automatic test_pof_write();
        int l, s, v, e; logic [23:0] a;
        @(negedge clk) begin pof_wr_en = 1'b1; pof_wr_data = 1'b0; end
        @(negedge clk) pof_wr_en = 1'b0;
        check(!pof, "R9 software clear", int'(pof), 0);
        observe(0, 2, -1, 1, l, s, v, a, e);
        check(!pof, "R9 warm reset leaves pof clear", int'(pof), 0);
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) begin supply_ok = 1'b1; pof_wr_en = 1'b1; pof_wr_data = 1'b0; end
        @(negedge clk) pof_wr_en = 1'b0;
        check(pof, "R9 supply rise wins over write", int'(pof), 1);
    endtask

    initial begin
        rst = 1'b1; ext_rst_pin = 1'b0; wdt_ovf = 1'b0; wdt_cmp = 1'b0;
        supply_ok = 1'b0; pof_wr_en = 1'b0; pof_wr_data = 1'b0; fetch_ack = 1'b0;
        repeat (4) @(negedge clk);
        test_reset_state();
        rst = 1'b0;
        test_reset_state();
        test_cold_start();
        test_short_pin();
        test_long_pin();
        test_pin_70();
        test_wdt(1, "ovf");
        test_wdt(2, "cmp");
        test_retrigger();
        test_fetch_hold();
        test_async_force();
        test_pof_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule